// File: doc/BRIEF.md
# Tone Transceiver Serial Control and Status Port

This block is the serial configuration port of a telephone tone transceiver. An external controller drives a serial clock, an enable strobe, a direction select and a data line. With the direction select low, the controller clocks a 14-bit control word into a holding register, most significant bit first. Raising the enable then copies that word into the active control register. The active control register sets the operating mode and supplies the squelch, detect-time, gain and transmit-frequency fields to the rest of the chip.

With the direction select high, the same port reads back the 4-bit code of the last received tone. A rising enable edge loads the code into a status shifter and drives its least significant bit onto the data output straight away. Each following serial clock rising edge then presents the next bit. The serial inputs are asynchronous to the system clock. They pass through a parameterised synchronizer, and the edges are detected in the system clock domain.

The data output is a plain output with a separate drive-enable. The drive-enable is off during writes and in both sleep modes, and the pad logic turns this into a high-impedance state.

Top module: `tone_ser_port`

## Requirements
- R1: With direction low, every serial clock rising edge shifts the synchronized data bit into the holding register at the least significant end, so the first bit sent ends up as bit 13 (mode bit 2) and the last as bit 0 (frequency bit 0).
- R2: While enable is high with direction low, the active control register takes the holding register's value. Reset clears the active control register to zero, which selects receive mode.
- R3: While enable is low, the active control register keeps its value, even as bits are shifted into the holding register.
- R4: The active word is split by bit position: mode = bits 13..11, squelch = bit 10, detect time = bits 9..8, gain = bits 7..4, transmit frequency = bits 3..0.
- R5: Mode decode: 000 enables the receiver; 001 enables dual-tone transmit; 010 enables single-tone transmit; 011 is sleep with the oscillator kept on; 100 is sleep with the oscillator off; 101 enables loopback together with the receiver. At most one of dual transmit, single transmit, loopback and sleep is active.
- R6: Mode codes 110 and 111 behave as 100: sleep with the oscillator off.
- R7: With squelch set, both transmit enables are off. Squelch has no effect on receive or loopback.
- R8: With direction high, an enable rising edge loads the 4-bit tone code, and bit 0 of that code appears on the data output.
- R9: Each of the following serial clock rising edges (direction high) shifts the status right, presenting bits 1, 2 and 3 in turn, then zeros.
- R10: The data drive-enable is high only with direction high and the block not in either sleep mode.
- R11: With direction high, serial clock edges leave the holding register unchanged and enable does not commit a word.
- R12: A change on a serial input takes effect on the outputs on the third system clock edge after it is applied (two synchronizer stages plus one register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| en_i | input | 1 | Enable strobe, asynchronous |
| dir_i | input | 1 | Direction select: 0 write, 1 read |
| sdi_i | input | 1 | Serial write data |
| tone_code_i | input | 4 | Received-tone code from the detector |
| dout_o | output | 1 | Serial read data |
| dout_en_o | output | 1 | Drive-enable for the read data pad |
| mode_o | output | 3 | Active mode field |
| sq_o | output | 1 | Transmit squelch field |
| det_time_o | output | 2 | Detect/release time field |
| gain_o | output | 4 | Transmit attenuation/gain field |
| freq_o | output | 4 | Transmit frequency field |
| rx_en_o | output | 1 | Receiver enable |
| tx_dual_en_o | output | 1 | Dual-tone transmitter enable |
| tx_single_en_o | output | 1 | Single-tone transmitter enable |
| loop_en_o | output | 1 | Analog loopback enable |
| osc_en_o | output | 1 | Oscillator enable |
| sleep_o | output | 1 | Either sleep mode active |

## Verification
A bad bit in the holding register stays hidden until the next commit. After that commit it shows on a field or mode enable output on the following cycle, so every check commits a word and compares all fields on each clock. A wrong active word shows on the decoded enables in the same cycle it is registered. A wrong status shifter shows on the data output one cycle after the load or shift edge, once the input synchronizer latency has passed. Errors in the edge detector or synchronizer show up as shifts or commits one or more cycles off from the model's timing.

// File: rtl/tonesp_pkg.sv
`timescale 1ns/1ps
package tonesp_pkg;
    localparam int MODE_W = 3;
    localparam int DET_W  = 2;
    localparam int GAIN_W = 4;
    localparam int FREQ_W = 4;
    localparam int CTRL_W = MODE_W + 1 + DET_W + GAIN_W + FREQ_W;

    typedef enum logic [MODE_W-1:0] {
        MD_RX        = 3'd0,
        MD_TX_DUAL   = 3'd1,
        MD_TX_SINGLE = 3'd2,
        MD_SLEEP_OSC = 3'd3,
        MD_SLEEP_ALL = 3'd4,
        MD_LOOP      = 3'd5,
        MD_RSV6      = 3'd6,
        MD_RSV7      = 3'd7
    } mode_e;

    // Field order follows the serial bit order (first bit sent = msb)
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              sq;
        logic [DET_W-1:0]  det;
        logic [GAIN_W-1:0] gain;
        logic [FREQ_W-1:0] freq;
    } ctrl_word_t;

    typedef struct packed {
        logic rx;
        logic tx_dual;
        logic tx_single;
        logic loop;
        logic osc;
        logic sleep;
    } enables_t;
endpackage

// File: rtl/tsp_in_sync.sv
`timescale 1ns/1ps
module tsp_in_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/tsp_edge_det.sv
`timescale 1ns/1ps
module tsp_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.prev;
endmodule

// File: rtl/tsp_wr_path.sv
`timescale 1ns/1ps
module tsp_wr_path #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         commit_i,
    output logic [W-1:0] hold_o,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) st_d.word = st_q.hold;
        if (shift_i)  st_d.hold = {st_q.hold[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign word_o = st_q.word;
endmodule

// File: rtl/tsp_rd_path.sv
`timescale 1ns/1ps
module tsp_rd_path #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] stat_o,
    output logic         dout_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)       st_d.stat = code_i;
        else if (shift_i) st_d.stat = {1'b0, st_q.stat[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign dout_o = st_q.stat[0];
endmodule

// File: rtl/tone_ser_port.sv
`timescale 1ns/1ps
module tone_ser_port
    import tonesp_pkg::*;
#(
    parameter int STAT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              en_i,
    input  logic              dir_i,
    input  logic              sdi_i,
    input  logic [STAT_W-1:0] tone_code_i,
    output logic              dout_o,
    output logic              dout_en_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              sq_o,
    output logic [DET_W-1:0]  det_time_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic              rx_en_o,
    output logic              tx_dual_en_o,
    output logic              tx_single_en_o,
    output logic              loop_en_o,
    output logic              osc_en_o,
    output logic              sleep_o
);
    localparam int N_IN   = 4;
    localparam int N_EDGE = 2;

    logic [N_IN-1:0]   lvl;
    logic [N_EDGE-1:0] rise;
    logic              sdi_lvl, dir_lvl, en_lvl;
    logic              sclk_rise, en_rise;
    logic [CTRL_W-1:0] hold, word;
    logic [STAT_W-1:0] stat;
    ctrl_word_t        cw;
    enables_t          ena;

    tsp_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, en_i, dir_i, sdi_i}),
        .lvl_o   (lvl)
    );

    tsp_edge_det #(.W(N_EDGE)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl[N_IN-1:N_IN-N_EDGE]),
        .rise_o (rise)
    );

    assign sdi_lvl   = lvl[0];
    assign dir_lvl   = lvl[1];
    assign en_lvl    = lvl[2];
    assign en_rise   = rise[0];
    assign sclk_rise = rise[1];

    tsp_wr_path #(.W(CTRL_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (sclk_rise & ~dir_lvl),
        .bit_i    (sdi_lvl),
        .commit_i (en_lvl & ~dir_lvl),
        .hold_o   (hold),
        .word_o   (word)
    );

    tsp_rd_path #(.W(STAT_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (en_rise & dir_lvl),
        .shift_i (sclk_rise & dir_lvl),
        .code_i  (tone_code_i),
        .stat_o  (stat),
        .dout_o  (dout_o)
    );

    assign cw = ctrl_word_t'(word);

    // Mode decode of the active word
    always_comb begin
        ena     = '0;
        ena.osc = 1'b1;
        case (mode_e'(cw.mode))
            MD_RX:        ena.rx        = 1'b1;
            MD_TX_DUAL:   ena.tx_dual   = ~cw.sq;
            MD_TX_SINGLE: ena.tx_single = ~cw.sq;
            MD_SLEEP_OSC: ena.sleep     = 1'b1;
            MD_LOOP: begin
                ena.loop = 1'b1;
                ena.rx   = 1'b1;
            end
            default: begin
                ena.sleep = 1'b1;
                ena.osc   = 1'b0;
            end
        endcase
    end

    assign mode_o         = cw.mode;
    assign sq_o           = cw.sq;
    assign det_time_o     = cw.det;
    assign gain_o         = cw.gain;
    assign freq_o         = cw.freq;
    assign rx_en_o        = ena.rx;
    assign tx_dual_en_o   = ena.tx_dual;
    assign tx_single_en_o = ena.tx_single;
    assign loop_en_o      = ena.loop;
    assign osc_en_o       = ena.osc;
    assign sleep_o        = ena.sleep;
    assign dout_en_o      = dir_lvl & ~ena.sleep;
endmodule

// File: rtl/tone_ser_port_chk.sv
`timescale 1ns/1ps
module tone_ser_port_chk
    import tonesp_pkg::*;
#(
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdi_lvl,
    input logic              en_lvl,
    input logic              dir_lvl,
    input logic              en_rise,
    input logic              sclk_rise,
    input logic [CTRL_W-1:0] hold,
    input logic [CTRL_W-1:0] word,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] tone_code,
    input logic              dout,
    input logic              dout_en,
    input logic              tx_dual,
    input logic              tx_single,
    input logic              loop,
    input logic              osc,
    input logic              sleep
);
    ctrl_word_t cw;
    assign cw = ctrl_word_t'(word);

    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !dir_lvl) |=>
            (hold == {$past(hold[CTRL_W-2:0]), $past(sdi_lvl)}));

    a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lvl && !dir_lvl) |=> (word == $past(hold)));

    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_lvl && !dir_lvl) |=> $stable(word));

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_dual, tx_single, loop, sleep}));

    a_r6_reserved_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.mode[2] && cw.mode[1]) |-> (sleep && !osc));

    a_r7_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        cw.sq |-> !(tx_dual || tx_single));

    a_r8_load_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && dir_lvl) |=> (dout == $past(tone_code[0])));

    a_r9_shift_out: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && dir_lvl && !en_rise) |=> (dout == $past(stat[1])));

    a_r10_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_lvl || sleep) |-> !dout_en);
endmodule

bind tone_ser_port tone_ser_port_chk #(.STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdi_lvl   (sdi_lvl),
    .en_lvl    (en_lvl),
    .dir_lvl   (dir_lvl),
    .en_rise   (en_rise),
    .sclk_rise (sclk_rise),
    .hold      (hold),
    .word      (word),
    .stat      (stat),
    .tone_code (tone_code_i),
    .dout      (dout_o),
    .dout_en   (dout_en_o),
    .tx_dual   (tx_dual_en_o),
    .tx_single (tx_single_en_o),
    .loop      (loop_en_o),
    .osc       (osc_en_o),
    .sleep     (sleep_o)
);

// File: tb/tone_ser_port_bench.sv
`timescale 1ns/1ps
module tone_ser_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int WD_LIMIT   = 100000;
    localparam int GAP        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, en = 1'b0, dir = 1'b0, sdi = 1'b0;
    logic [3:0] tone = 4'h0;
    logic       dout, dout_en, sq, rx_en, tx_dual, tx_single, loop_en, osc_en, sleep;
    logic [2:0] mode;
    logic [1:0] det;
    logic [3:0] gain, freq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_ser_port u_tone_ser_port (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_i         (sclk),
        .en_i           (en),
        .dir_i          (dir),
        .sdi_i          (sdi),
        .tone_code_i    (tone),
        .dout_o         (dout),
        .dout_en_o      (dout_en),
        .mode_o         (mode),
        .sq_o           (sq),
        .det_time_o     (det),
        .gain_o         (gain),
        .freq_o         (freq),
        .rx_en_o        (rx_en),
        .tx_dual_en_o   (tx_dual),
        .tx_single_en_o (tx_single),
        .loop_en_o      (loop_en),
        .osc_en_o       (osc_en),
        .sleep_o        (sleep)
    );

    // ---------------- reference model ----------------
    logic [3:0]  hist[$];
    logic [13:0] m_hold = '0, m_word = '0;
    logic [3:0]  m_stat = '0;

    function automatic logic [13:0] mk(input int md, input int s, input int dt,
                                       input int g, input int f);
        logic [13:0] w;
        w = {md[2:0], s[0], dt[1:0], g[3:0], f[3:0]};
        return w;
    endfunction

    // {rx, tx_dual, tx_single, loop, osc, sleep} from R5, R6, R7
    function automatic logic [5:0] exp_en(input logic [13:0] w);
        logic s;
        s = w[10];
        case (w[13:11])
            3'd0: return 6'b100010;
            3'd1: return {1'b0, ~s, 4'b0010};
            3'd2: return {2'b00, ~s, 3'b010};
            3'd3: return 6'b000011;
            3'd5: return 6'b100110;
            default: return 6'b000001;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [3:0] cur, prv;
        logic       sr, er;
        cycles++;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < SYNC + 2; i++) hist.push_back(4'h0);
            m_hold = '0; m_word = '0; m_stat = '0;
        end else begin
            hist.push_front({sclk, en, dir, sdi});
            void'(hist.pop_back());
            cur = hist[SYNC];
            prv = hist[SYNC+1];
            sr  = cur[3] & ~prv[3];
            er  = cur[2] & ~prv[2];
            if (cur[2] && !cur[1]) m_word = m_hold;
            if (sr && !cur[1])     m_hold = {m_hold[12:0], cur[0]};
            if (er && cur[1])      m_stat = tone;
            else if (sr && cur[1]) m_stat = m_stat >> 1;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [5:0] e;
        if (rst_n && !done) begin
            e = exp_en(m_word);
            check("R2/R4 active word", {2'b0, mode, sq, det, gain, freq}, {2'b0, m_word});
            check("R5 mode enables", {10'b0, rx_en, tx_dual, tx_single, loop_en, osc_en, sleep},
                  {10'b0, e});
            check("R8/R9 data out", {15'b0, dout}, {15'b0, m_stat[0]});
            check("R10 drive enable", {15'b0, dout_en},
                  {15'b0, hist[SYNC-1][1] & ~e[0]});
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        if (cycles >= WD_LIMIT && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [13:0] w);
        dir = 1'b0;
        for (int i = 13; i >= 0; i--) begin
            sdi = w[i];
            wait_n(GAP);
            sclk = 1'b1;
            wait_n(GAP);
            sclk = 1'b0;
        end
        wait_n(GAP);
    endtask

    task automatic commit();
        en = 1'b1;
        wait_n(GAP);
        en = 1'b0;
        wait_n(GAP);
    endtask

    task automatic write_word(input logic [13:0] w);
        send_word(w);
        commit();
    endtask

    task automatic read_code(input logic [3:0] code);
        dir  = 1'b1;
        tone = code;
        wait_n(GAP);
        en = 1'b1;
        wait_n(GAP);
        check("R8 first bit", {15'b0, dout}, {15'b0, code[0]});
        check("R10 drive on in read", {15'b0, dout_en}, 16'h1);
        for (int i = 1; i < 4; i++) begin
            sclk = 1'b1;
            wait_n(GAP);
            check("R9 next bit", {15'b0, dout}, {15'b0, code[i]});
            sclk = 1'b0;
            wait_n(GAP);
        end
        sclk = 1'b1;
        wait_n(GAP);
        check("R9 zero after last bit", {15'b0, dout}, 16'h0);
        sclk = 1'b0;
        en   = 1'b0;
        wait_n(GAP);
        dir = 1'b0;
        wait_n(GAP);
    endtask

    initial begin
        logic [13:0] w1, w2, w3;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        check("R2 reset word", {2'b0, mode, sq, det, gain, freq}, 16'h0);
        check("R5 reset receive", {15'b0, rx_en}, 16'h1);
        check("R10 reset drive off", {15'b0, dout_en}, 16'h0);

        // R1, R3, R4, R5: write then commit
        w1 = mk(1, 0, 2, 10, 6);
        send_word(w1);
        check("R3 no commit while enable low", {2'b0, mode, sq, det, gain, freq}, 16'h0);
        commit();
        check("R1/R4 mode field", {13'b0, mode}, 16'd1);
        check("R4 detect field", {14'b0, det}, 16'd2);
        check("R4 gain field", {12'b0, gain}, 16'hA);
        check("R4 freq field", {12'b0, freq}, 16'h6);
        check("R5 dual transmit", {15'b0, tx_dual}, 16'h1);

        // R12: commit latency
        w2 = mk(0, 0, 1, 3, 9);
        send_word(w2);
        en = 1'b1;
        wait_n(2);
        check("R12 not yet committed", {2'b0, mode, sq, det, gain, freq}, {2'b0, w1});
        wait_n(1);
        check("R12 committed on third edge", {2'b0, mode, sq, det, gain, freq}, {2'b0, w2});
        en = 1'b0;
        wait_n(GAP);

        // R7 squelch
        write_word(mk(2, 1, 1, 1, 4));
        check("R7 single squelched", {15'b0, tx_single}, 16'h0);
        check("R7 squelch field", {15'b0, sq}, 16'h1);
        write_word(mk(2, 0, 1, 1, 4));
        check("R5 single transmit", {15'b0, tx_single}, 16'h1);
        write_word(mk(1, 1, 3, 15, 15));
        check("R7 dual squelched", {15'b0, tx_dual}, 16'h0);

        // R5, R10 sleep with oscillator
        write_word(mk(3, 0, 0, 0, 0));
        check("R5 sleep osc on", {14'b0, osc_en, sleep}, 16'h3);
        dir = 1'b1;
        wait_n(GAP);
        check("R10 drive off in sleep", {15'b0, dout_en}, 16'h0);
        dir = 1'b0;
        wait_n(GAP);

        // R5, R6 full sleep codes
        for (int m = 4; m < 8; m++) begin
            if (m == 5) continue;
            write_word(mk(m, 0, 1, 2, 3));
            check(m == 4 ? "R5 full sleep" : "R6 reserved is full sleep",
                  {14'b0, osc_en, sleep}, 16'h1);
        end

        // R5, R7 loopback unaffected by squelch
        write_word(mk(5, 1, 2, 7, 8));
        check("R7 loopback with squelch", {14'b0, loop_en, rx_en}, 16'h3);

        // R8, R9 reads in receive mode
        write_word(mk(0, 0, 1, 0, 0));
        read_code(4'hB);
        read_code(4'h4);

        // R11: read cycle leaves holding and active word alone
        w3 = mk(1, 0, 0, 5, 5);
        write_word(w3);
        send_word(mk(2, 0, 3, 12, 1));
        read_code(4'h9);
        check("R11 no commit in read", {2'b0, mode, sq, det, gain, freq}, {2'b0, w3});
        commit();
        check("R11 holding kept through read", {2'b0, mode, sq, det, gain, freq},
              {2'b0, mk(2, 0, 3, 12, 1)});

        wait_n(GAP);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule